// File: doc/BRIEF.md
# Locking Packet Timestamp Capture Unit

This block records the free-running time value when a packet that should be stamped passes the timing point of the link. There are two independent directions, transmit and receive. Each one holds exactly one 64-bit stamp. Once a stamp is held, that direction is locked. No later packet can overwrite the stamp until software reads the upper half, so the held value always belongs to the one outstanding packet.

An upstream parser supplies a start-of-frame strobe for each direction, together with classification flags. Transmit packets qualify when the parser raises a per-packet request flag. Receive packets qualify according to a two-bit mode held in the receive control word:
- version-1 event messages carried over UDP, with a Sync-type control code;
- the same, with a delay-request-type control code;
- any version-2 event message, at either layer;
- every packet.

The two version-1 control codes sit in a separate message-select word. Software reaches all state through a small register port. Reads are combinational and are returned in the same cycle. A read of a high word has a side effect, which takes effect at the clock edge.

Top module: `ts_capture_unit`

## Requirements
- R1: A transmit start-of-frame strobe with `tx_ts_req_i` high, while the transmit enable bit (control bit 0) is set and the lane is unlocked, stores `time_i` of that cycle. The valid flag (control bit 4, and `tx_valid_o`) reads 1 from the next cycle. The receive lane behaves the same way when its packet matches the selected mode.
- R2: While a lane's valid flag is set, no frame changes its stored stamp.
- R3: Reading the high word returns stamp bits 63:32. The same read clears the valid flag and the overrun flag of that lane from the next cycle on. Addresses: transmit high is 2, receive high is 5.
- R4: Reading the low word returns stamp bits 31:0 and leaves the valid flag set. Addresses: transmit low is 1, receive low is 4.
- R5: A start-of-frame strobe that would qualify, arriving while the lane is enabled and locked, sets the sticky overrun flag (control bit 5). The flag stays set until the next high-word read.
- R6: Receive mode 0 stamps a version-1 packet whose control code equals message-select bits 3:0. Mode 1 uses message-select bits 7:4 instead. Both modes ignore all other packets. Message-select is at address 6.
- R7: Receive mode 2 stamps any packet that is flagged both version-2 and event. It ignores version-1 packets and version-2 packets that are not events.
- R8: Receive mode 3 stamps every received frame, regardless of its flags.
- R9: With the enable bit clear, no frame is captured. Writing a control word changes only the enable bit and the mode bits; valid and overrun keep their values. Control addresses: transmit is 0, receive is 3. The mode sits in receive control bits 2:1.
- R10: After reset, both control words read 0 and message-select reads 0x10.
- R11: A transmit strobe with `tx_ts_req_i` low is never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Current time counter value |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe |
| tx_ts_req_i | input | 1 | Transmit packet asks for a stamp |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| rx_is_v1_i | input | 1 | Receive packet is a version-1 message over UDP |
| rx_is_v2_i | input | 1 | Receive packet is a version-2 message |
| rx_is_event_i | input | 1 | Receive packet is an event message |
| rx_msg_type_i | input | 4 | Receive message control code |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rd_i | input | 1 | Register read strobe (a high-word read releases the lock) |
| reg_rdata_o | output | 32 | Register read data, combinational |
| tx_valid_o | output | 1 | Transmit stamp held |
| rx_valid_o | output | 1 | Receive stamp held |

## Verification
The receive filter is exercised with a table of packets, covering every mode. The table pairs each mode with packets that ought to match, and with near misses:
- the other version-1 code;
- a version-2 packet that is not an event;
- a version-1 packet seen in version-2 mode.

These pairs separate a correct mode decode from one that swaps or merges modes.

Directed sequences then check the transmit lane:
- a second frame while locked, which separates true locking from overwriting and drives the overrun flag;
- a low-word read, which must leave the lock in place, followed by a high-word read, which must release it;
- control writes that must not disturb valid;
- a rewritten message-select code, which shows that the compare follows the register rather than a fixed value.

// File: rtl/ts_cap_pkg.sv
`timescale 1ns/1ps
package ts_cap_pkg;
  typedef enum logic [1:0] {
    RX_V1_SYNC  = 2'b00,
    RX_V1_DREQ  = 2'b01,
    RX_V2_EVENT = 2'b10,
    RX_ALL      = 2'b11
  } rx_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned N_DIR  = 2;
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  localparam logic [ADDR_W-1:0] A_TX_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TX_LO   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TX_HI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RX_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX_LO   = 3'd4;
  localparam logic [ADDR_W-1:0] A_RX_HI   = 3'd5;
  localparam logic [ADDR_W-1:0] A_MSGSEL  = 3'd6;

  // control word bit positions
  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_MODE  = 1;
  localparam int unsigned B_VALID = 4;
  localparam int unsigned B_OVR   = 5;
endpackage

// File: rtl/ts_rx_filter.sv
`timescale 1ns/1ps
module ts_rx_filter
  import ts_cap_pkg::*;
#(
  parameter int unsigned MSG_W = 4
) (
  input  rx_mode_e         mode_i,
  input  logic [MSG_W-1:0] sync_code_i,
  input  logic [MSG_W-1:0] dreq_code_i,
  input  logic             is_v1_i,
  input  logic             is_v2_i,
  input  logic             is_event_i,
  input  logic [MSG_W-1:0] msg_i,
  output logic             match_o
);
  always_comb begin
    unique case (mode_i)
      RX_V1_SYNC:  match_o = is_v1_i && (msg_i == sync_code_i);
      RX_V1_DREQ:  match_o = is_v1_i && (msg_i == dreq_code_i);
      RX_V2_EVENT: match_o = is_v2_i && is_event_i;
      default:     match_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ts_capture_lane.sv
`timescale 1ns/1ps
module ts_capture_lane #(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            sof_i,
  input  logic            match_i,
  input  logic            hi_rd_i,
  input  logic [TS_W-1:0] time_i,
  output logic            valid_o,
  output logic            ovr_o,
  output logic [TS_W-1:0] stamp_o
);
  logic qual, cap;

  assign qual = en_i && sof_i && match_i;
  assign cap  = qual && !valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
      stamp_o <= '0;
    end else begin
      if (cap) stamp_o <= time_i;
      valid_o <= cap || (valid_o && !hi_rd_i);
      // a drop in the release cycle still counts
      ovr_o   <= (ovr_o && !hi_rd_i) || (qual && valid_o);
    end
  end
endmodule

// File: rtl/ts_capture_unit.sv
`timescale 1ns/1ps
module ts_capture_unit
  import ts_cap_pkg::*;
#(
  parameter int unsigned TS_W  = 64,
  parameter int unsigned MSG_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TS_W-1:0]     time_i,
  input  logic                tx_sof_i,
  input  logic                tx_ts_req_i,
  input  logic                rx_sof_i,
  input  logic                rx_is_v1_i,
  input  logic                rx_is_v2_i,
  input  logic                rx_is_event_i,
  input  logic [MSG_W-1:0]    rx_msg_type_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_wr_i,
  input  logic [TS_W/2-1:0]   reg_wdata_i,
  input  logic                reg_rd_i,
  output logic [TS_W/2-1:0]   reg_rdata_o,
  output logic                tx_valid_o,
  output logic                rx_valid_o
);
  localparam int unsigned REG_W = TS_W / 2;

  logic [N_DIR-1:0]           en_q;
  rx_mode_e                   mode_q;
  logic [MSG_W-1:0]           sync_code_q, dreq_code_q;
  logic [N_DIR-1:0]           sof, match, hi_rd, valid, ovr;
  logic [N_DIR-1:0][TS_W-1:0] stamp;
  logic                       rx_match;
  logic [N_DIR-1:0][REG_W-1:0] ctrl_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= '0;
      mode_q      <= RX_V1_SYNC;
      sync_code_q <= MSG_W'(0);
      dreq_code_q <= MSG_W'(1);
    end else if (reg_wr_i) begin
      unique case (reg_addr_i)
        A_TX_CTRL: en_q[DIR_TX] <= reg_wdata_i[B_EN];
        A_RX_CTRL: begin
          en_q[DIR_RX] <= reg_wdata_i[B_EN];
          mode_q       <= rx_mode_e'(reg_wdata_i[B_MODE +: 2]);
        end
        A_MSGSEL: begin
          sync_code_q <= reg_wdata_i[MSG_W-1:0];
          dreq_code_q <= reg_wdata_i[2*MSG_W-1:MSG_W];
        end
        default: ;
      endcase
    end
  end

  ts_rx_filter #(.MSG_W(MSG_W)) i_rx_filter (
    .mode_i      (mode_q),
    .sync_code_i (sync_code_q),
    .dreq_code_i (dreq_code_q),
    .is_v1_i     (rx_is_v1_i),
    .is_v2_i     (rx_is_v2_i),
    .is_event_i  (rx_is_event_i),
    .msg_i       (rx_msg_type_i),
    .match_o     (rx_match)
  );

  assign sof[DIR_TX]   = tx_sof_i;
  assign sof[DIR_RX]   = rx_sof_i;
  assign match[DIR_TX] = tx_ts_req_i;
  assign match[DIR_RX] = rx_match;
  assign hi_rd[DIR_TX] = reg_rd_i && (reg_addr_i == A_TX_HI);
  assign hi_rd[DIR_RX] = reg_rd_i && (reg_addr_i == A_RX_HI);

  for (genvar d = 0; d < N_DIR; d++) begin : g_lane
    ts_capture_lane #(.TS_W(TS_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_q[d]),
      .sof_i   (sof[d]),
      .match_i (match[d]),
      .hi_rd_i (hi_rd[d]),
      .time_i  (time_i),
      .valid_o (valid[d]),
      .ovr_o   (ovr[d]),
      .stamp_o (stamp[d])
    );

    always_comb begin
      ctrl_word[d]          = '0;
      ctrl_word[d][B_EN]    = en_q[d];
      ctrl_word[d][B_VALID] = valid[d];
      ctrl_word[d][B_OVR]   = ovr[d];
      if (d == DIR_RX) ctrl_word[d][B_MODE +: 2] = mode_q;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_TX_CTRL: reg_rdata_o = ctrl_word[DIR_TX];
      A_TX_LO:   reg_rdata_o = stamp[DIR_TX][REG_W-1:0];
      A_TX_HI:   reg_rdata_o = stamp[DIR_TX][TS_W-1:REG_W];
      A_RX_CTRL: reg_rdata_o = ctrl_word[DIR_RX];
      A_RX_LO:   reg_rdata_o = stamp[DIR_RX][REG_W-1:0];
      A_RX_HI:   reg_rdata_o = stamp[DIR_RX][TS_W-1:REG_W];
      A_MSGSEL:  reg_rdata_o[2*MSG_W-1:0] = {dreq_code_q, sync_code_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign tx_valid_o = valid[DIR_TX];
  assign rx_valid_o = valid[DIR_RX];
endmodule

// File: rtl/ts_capture_unit_chk.sv
`timescale 1ns/1ps
module ts_capture_unit_chk
  import ts_cap_pkg::*;
#(
  parameter int unsigned TS_W = 64
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tx_sof_i,
  input logic                       tx_ts_req_i,
  input logic                       reg_rd_i,
  input logic [ADDR_W-1:0]          reg_addr_i,
  input logic [N_DIR-1:0]           en_q,
  input logic                       tx_valid_o,
  input logic                       rx_valid_o,
  input logic [N_DIR-1:0][TS_W-1:0] stamp
);
  logic tx_hi, rx_hi, tx_lo;
  assign tx_hi = reg_rd_i && (reg_addr_i == A_TX_HI);
  assign rx_hi = reg_rd_i && (reg_addr_i == A_RX_HI);
  assign tx_lo = reg_rd_i && (reg_addr_i == A_TX_LO);

  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[DIR_TX] && !tx_valid_o && tx_sof_i && tx_ts_req_i) |=> tx_valid_o);

  p_hold_tx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_hi) |=> $stable(stamp[DIR_TX]));

  p_hold_rx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_hi) |=> $stable(stamp[DIR_RX]));

  p_release_tx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_hi) |=> !tx_valid_o);

  p_release_rx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && rx_hi) |=> !rx_valid_o);

  p_lo_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_lo) |=> tx_valid_o);

  p_disabled_tx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[DIR_TX] && !tx_valid_o) |=> !tx_valid_o);

  p_disabled_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[DIR_RX] && !rx_valid_o) |=> !rx_valid_o);

  p_no_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_valid_o && !tx_ts_req_i) |=> !tx_valid_o);
endmodule

bind ts_capture_unit ts_capture_unit_chk #(.TS_W(TS_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_sof_i    (tx_sof_i),
  .tx_ts_req_i (tx_ts_req_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .en_q        (en_q),
  .tx_valid_o  (tx_valid_o),
  .rx_valid_o  (rx_valid_o),
  .stamp       (stamp)
);

// File: tb/test_ts_capture_unit.sv
`timescale 1ns/1ps
module test_ts_capture_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] time_i = '0;
  logic        tx_sof_i = 0, tx_ts_req_i = 0, rx_sof_i = 0;
  logic        rx_is_v1_i = 0, rx_is_v2_i = 0, rx_is_event_i = 0;
  logic [3:0]  rx_msg_type_i = '0;
  logic [2:0]  reg_addr_i = '0;
  logic        reg_wr_i = 0, reg_rd_i = 0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_valid_o, rx_valid_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #5 clk_i = ~clk_i;

  ts_capture_unit i_ts_capture_unit (.*);

  // {mode[1:0], v1, v2, event, msg[3:0], expect}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b1, 4'd1, 1'b0},
    {2'd0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1, 4'd1, 1'b1},
    {2'd1, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1, 4'd3, 1'b1},
    {2'd2, 1'b0, 1'b1, 1'b0, 4'd3, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 4'd9, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b0, 4'd7, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_rd_i = 1;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_rd_i = 0;
  endtask

  task automatic tx_frame(input logic req, input logic [63:0] t);
    @(negedge clk_i);
    tx_sof_i = 1; tx_ts_req_i = req; time_i = t;
    @(negedge clk_i);
    tx_sof_i = 0; tx_ts_req_i = 0; time_i = ~t;
  endtask

  task automatic rx_frame(input logic v1, input logic v2, input logic ev,
                          input logic [3:0] msg, input logic [63:0] t);
    @(negedge clk_i);
    rx_sof_i = 1; rx_is_v1_i = v1; rx_is_v2_i = v2; rx_is_event_i = ev;
    rx_msg_type_i = msg; time_i = t;
    @(negedge clk_i);
    rx_sof_i = 0; rx_is_v1_i = 0; rx_is_v2_i = 0; rx_is_event_i = 0;
    time_i = ~t;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R10 reset state
    rdr(3'd0, rd); check("R10 tx ctrl", rd, 32'h0);
    rdr(3'd3, rd); check("R10 rx ctrl", rd, 32'h0);
    rdr(3'd6, rd); check("R10 msgsel", rd, 32'h10);

    // receive filter table
    for (int i = 0; i < NV; i++) begin
      logic [9:0]  v;
      logic [63:0] t;
      string       tag;
      v = VEC[i];
      t = {32'hA000_0000 + 32'(i), 32'h0000_1000 + 32'(i)};
      case (v[9:8])
        2'd0, 2'd1: tag = "R6";
        2'd2:       tag = "R7";
        default:    tag = "R8";
      endcase
      wr(3'd3, {29'd0, v[9:8], 1'b1});
      rx_frame(v[7], v[6], v[5], v[4:1], t);
      rdr(3'd3, rd);
      check(tag, rd, {26'd0, 1'b0, v[0], 1'b0, v[9:8], 1'b1});
      if (v[0]) begin
        rdr(3'd4, rd); check(tag, rd, t[31:0]);
        rdr(3'd5, rd); check(tag, rd, t[63:32]);
      end
    end
    wr(3'd3, 32'h0);

    // R9 disabled transmit
    tx_frame(1'b1, 64'h1111_2222_3333_4444);
    rdr(3'd0, rd); check("R9 disabled", rd, 32'h0);

    wr(3'd0, 32'h1);
    // R11 no request
    tx_frame(1'b0, 64'h5555_6666_7777_8888);
    rdr(3'd0, rd); check("R11 no request", rd, 32'h1);

    // R1 capture
    tx_frame(1'b1, 64'hDEAD_BEEF_0123_4567);
    #1 check("R1 tx_valid_o", {31'd0, tx_valid_o}, 32'h1);
    rdr(3'd0, rd); check("R1 ctrl", rd, 32'h11);

    // R2/R5 locked frame
    tx_frame(1'b1, 64'h9999_AAAA_BBBB_CCCC);
    rdr(3'd0, rd); check("R5 overrun", rd, 32'h31);
    rdr(3'd1, rd); check("R2 held low", rd, 32'h0123_4567);
    rdr(3'd0, rd); check("R4 lo keeps lock", rd, 32'h31);

    // R9 control write keeps status
    wr(3'd0, 32'hFFFF_FFF1);
    rdr(3'd0, rd); check("R9 write keeps valid", rd, 32'h31);

    // R3 release
    rdr(3'd2, rd); check("R3 hi word", rd, 32'hDEAD_BEEF);
    rdr(3'd0, rd); check("R3 cleared", rd, 32'h1);
    #1 check("R3 tx_valid_o", {31'd0, tx_valid_o}, 32'h0);

    // R1 recapture after release
    tx_frame(1'b1, 64'h0BAD_F00D_CAFE_0001);
    rdr(3'd1, rd); check("R1 new low", rd, 32'hCAFE_0001);

    // R9 disable while locked
    wr(3'd0, 32'h0);
    rdr(3'd0, rd); check("R9 disable keeps valid", rd, 32'h10);
    rdr(3'd2, rd); check("R3 hi second", rd, 32'h0BAD_F00D);
    tx_frame(1'b1, 64'h1234_5678_9ABC_DEF0);
    rdr(3'd0, rd); check("R9 no capture when off", rd, 32'h0);

    // R6 rewritten sync code
    wr(3'd6, 32'h15);
    wr(3'd3, 32'h1);
    rx_frame(1'b1, 1'b0, 1'b1, 4'd0, 64'h1);
    #1 check("R6 old code ignored", {31'd0, rx_valid_o}, 32'h0);
    rx_frame(1'b1, 1'b0, 1'b1, 4'd5, 64'h0000_0042_0000_0024);
    #1 check("R6 new code", {31'd0, rx_valid_o}, 32'h1);
    rdr(3'd5, rd); check("R6 hi", rd, 32'h42);

    finish_run();
  end
endmodule